// File: doc/BRIEF.md
# Paged Processor Register Interface for a Time-Slot Switch

This block is the 8-bit host port of a time-slot interchange switch. A host drives a 6-bit address, an active-low chip select, an active-high data strobe, a read/write line and write data. The block returns read data and an active-low acknowledge, which stands in for an open-drain completion line. The host lines are asynchronous to the block clock, so chip select and strobe pass through a synchronizer. An access starts once chip select is low and the strobe is high. The acknowledge then stays low until the strobe is released.

The block keeps one 8-bit control register. That register sets a global processor-mode flag for the switching core. It also chooses which internal memory the upper half of the address space reaches, and which 32-channel stream of that memory appears there. Each window access becomes a single request on a shared memory port. The request waits for a grant, then takes a fixed number of cycles before the acknowledge. Control register accesses are acknowledged at once.

Top module: `tsi_cpu_port`

## Requirements
- R1: After reset, `ack_n` is high, `mem_req` is low, `proc_mode` is 0, and a control register read returns 0x00.
- R2: With `addr[5]`=0 an access reaches the control register and `addr[4:0]` has no effect. A read returns the last written byte with bits 5 and 2 forced to 0.
- R3: A control register access, or an ignored window access, raises no memory request. Its acknowledge is low within 4 clocks of the strobe becoming active.
- R4: `proc_mode` equals control register bit 6 at all times.
- R5: When control bit 7 is 0, a window access (`addr[5]`=1) requests the memory coded by control bits 4:3: 01 is data memory, 10 is connection low, 11 is connection high. `mem_sel` carries that code, and `mem_addr` = {control bits 1:0, `addr[4:0]`}.
- R6: When control bit 7 is 1, window reads request the data memory (`mem_sel`=01) and window writes request connection low (`mem_sel`=10), whatever bits 4:3 hold.
- R7: A window write that would reach the data memory, or any window access while code 00 is selected, raises no request and is still acknowledged. A read under code 00 returns 0x00, and the data memory keeps its contents.
- R8: Connection-high reads return the stored byte masked with 0x05. Connection-high writes present `mem_wdata` masked with 0x05.
- R9: `mem_req` stays high, with `mem_sel`, `mem_addr` and `mem_we` stable, until a cycle with `mem_gnt` high. `ack_n` goes low exactly MEM_WAIT clocks after that grant cycle.
- R10: `ack_n` stays low while the strobe stays active, and returns high within 4 clocks after the strobe is released.
- R11: A window read returns on `rdata` the byte the memory presents in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| ds | input | 1 | Host data strobe, active high, asynchronous |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Host address; bit 5 picks window versus control register |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid while `ack_n` is low |
| ack_n | output | 1 | Access complete, active low |
| proc_mode | output | 1 | Global processor-mode enable for the switching core |
| mem_req | output | 1 | Memory port request |
| mem_gnt | input | 1 | Memory port slot free; request taken this cycle |
| mem_we | output | 1 | 1 = write request |
| mem_sel | output | 2 | Target memory code (01 data, 10 connection low, 11 connection high) |
| mem_addr | output | 7 | {stream, channel} location |
| mem_wdata | output | 8 | Write byte to memory |
| mem_rdata | input | 8 | Read byte, valid the cycle after the grant |

## Verification
Two things can fall in the same cycle. A control register write may change the page, mode or split setting in the very cycle that the next window access is decoded. The bench provokes this by issuing accesses back to back, with only the release handshake between them, and by mixing random control writes into a random stream of window accesses. Each window request is judged against a bench model of the control register as most recently written. The target code, location, direction and write byte must all follow the new setting. The grant is also withheld for a random number of cycles, to confirm that the request holds steady and that the acknowledge timing counts from the grant.

// File: rtl/tsi_cpu_pkg.sv
// Shared types and field positions for the paged host port.
// Assumes an 8-bit control register whose field positions are fixed.
package tsi_cpu_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_DATA = 2'b01,
        SEL_CLO  = 2'b10,
        SEL_CHI  = 2'b11
    } mem_sel_e;

    typedef enum logic [1:0] {
        ACC_CTRL = 2'd0,
        ACC_MEM  = 2'd1,
        ACC_NULL = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_ACK  = 2'd3
    } fsm_state_e;

    localparam logic [7:0] CR_KEEP  = 8'hDB;  // bits 5 and 2 unimplemented
    localparam logic [7:0] CHI_KEEP = 8'h05;  // only bits 2 and 0 exist
endpackage

// File: rtl/tsi_strobe_sync.sv
// Brings the asynchronous chip select and strobe into the clock domain.
// Assumes STAGES >= 1; output is high while a host access is active.
module tsi_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ds,
    output logic active
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] ds_pipe;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first capture flop of each host line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cs_pipe[0] <= 1'b1;
                    ds_pipe[0] <= 1'b0;
                end else begin
                    cs_pipe[0] <= cs_n;
                    ds_pipe[0] <= ds;
                end
            end
        end else begin : g_next
            // further metastability filter stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cs_pipe[g] <= 1'b1;
                    ds_pipe[g] <= 1'b0;
                end else begin
                    cs_pipe[g] <= cs_pipe[g-1];
                    ds_pipe[g] <= ds_pipe[g-1];
                end
            end
        end
    end

    assign active = !cs_pipe[STAGES-1] && ds_pipe[STAGES-1];
endmodule

// File: rtl/tsi_page_decode.sv
// Maps a host address and the control fields onto a target memory and location.
// Purely combinational; assumes the control fields are stable during decode.
module tsi_page_decode #(
    parameter int CH_W = 5,
    parameter int ST_W = 2,
    localparam int MA_W = CH_W + ST_W
) (
    input  logic                       win,
    input  logic [CH_W-1:0]            chan,
    input  logic                       rd,
    input  logic                       split,
    input  logic [1:0]                 sel_code,
    input  logic [ST_W-1:0]            stream,
    output tsi_cpu_pkg::acc_kind_e     kind,
    output tsi_cpu_pkg::mem_sel_e      sel,
    output logic [MA_W-1:0]            maddr
);
    import tsi_cpu_pkg::*;

    // choose the target memory and classify the access
    always_comb begin
        if (split) sel = rd ? SEL_DATA : SEL_CLO;
        else       sel = mem_sel_e'(sel_code);
        if (!win)
            kind = ACC_CTRL;
        else if (sel == SEL_NONE || (sel == SEL_DATA && !rd))
            kind = ACC_NULL;
        else
            kind = ACC_MEM;
    end

    assign maddr = {stream, chan};
endmodule

// File: rtl/tsi_access_fsm.sv
// Sequences one host access: control register, ignored window, or memory request.
// Assumes rd_wr, addr and wdata are stable while the strobe is active.
module tsi_access_fsm #(
    parameter int DW       = 8,
    parameter int MA_W     = 7,
    parameter int MEM_WAIT = 3,
    localparam int CW = (MEM_WAIT > 1) ? $clog2(MEM_WAIT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic                    rd,
    input  logic [DW-1:0]           wdata,
    input  tsi_cpu_pkg::acc_kind_e  kind,
    input  tsi_cpu_pkg::mem_sel_e   sel,
    input  logic [MA_W-1:0]         maddr,
    input  logic [DW-1:0]           cr,
    input  logic                    mem_gnt,
    input  logic [DW-1:0]           mem_rdata,
    output logic                    cr_we,
    output logic                    ack_n,
    output logic [DW-1:0]           rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [1:0]              mem_sel,
    output logic [MA_W-1:0]         mem_addr,
    output logic [DW-1:0]           mem_wdata
);
    import tsi_cpu_pkg::*;

    fsm_state_e     state;
    logic [CW-1:0]  cnt;
    mem_sel_e       req_sel;
    logic [DW-1:0]  rdata_q;

    assign cr_we = (state == ST_IDLE) && active && (kind == ACC_CTRL) && !rd;

    // access state machine, request latch and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            req_sel   <= SEL_NONE;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (active) begin
                    case (kind)
                        ACC_CTRL: begin
                            rdata_q <= rd ? (cr & CR_KEEP) : '0;
                            state   <= ST_ACK;
                        end
                        ACC_MEM: begin
                            req_sel   <= sel;
                            mem_we    <= !rd;
                            mem_addr  <= maddr;
                            mem_wdata <= (sel == SEL_CHI) ? (wdata & CHI_KEEP) : wdata;
                            state     <= ST_REQ;
                        end
                        default: begin
                            rdata_q <= '0;
                            state   <= ST_ACK;
                        end
                    endcase
                end
                ST_REQ: if (mem_gnt) begin
                    cnt   <= '0;
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cnt == '0 && !mem_we)
                        rdata_q <= (req_sel == SEL_CHI) ? (mem_rdata & CHI_KEEP) : mem_rdata;
                    if (cnt == CW'(MEM_WAIT - 1)) state <= ST_ACK;
                    else                          cnt   <= cnt + 1'b1;
                end
                default: if (!active) state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req = (state == ST_REQ);
    assign mem_sel = req_sel;
    assign ack_n   = (state != ST_ACK);
    assign rdata   = rdata_q;

    // R9: request and its fields hold until granted
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_sel) && $stable(mem_we));

    // R10: acknowledge held while the strobe is still active
    assert_ack_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n && active |=> !ack_n);

    // R7: never a data memory write nor a reserved-code request
    assert_no_dm_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !(mem_we && mem_sel == SEL_DATA) && mem_sel != SEL_NONE);

    // R3: no memory request overlaps an acknowledge
    assert_req_ack_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !mem_req);
endmodule

// File: rtl/tsi_cpu_port.sv
// Host port of the switch: control register plus paged window onto the memories.
// Assumes one memory port shared with the serial side, arbitrated by mem_gnt.
module tsi_cpu_port #(
    parameter int DW          = 8,
    parameter int CH_W        = 5,
    parameter int ST_W        = 2,
    parameter int MEM_WAIT    = 3,
    parameter int SYNC_STAGES = 2,
    localparam int MA_W = CH_W + ST_W,
    localparam int AW   = CH_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            ds,
    input  logic            rd_wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            ack_n,
    output logic            proc_mode,
    output logic            mem_req,
    input  logic            mem_gnt,
    output logic            mem_we,
    output logic [1:0]      mem_sel,
    output logic [MA_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    import tsi_cpu_pkg::*;

    logic            active;
    logic            cr_we;
    logic [DW-1:0]   cr_q;
    acc_kind_e       kind;
    mem_sel_e        sel;
    logic [MA_W-1:0] maddr;

    tsi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .active(active)
    );

    tsi_page_decode #(.CH_W(CH_W), .ST_W(ST_W)) u_decode (
        .win(addr[AW-1]), .chan(addr[CH_W-1:0]), .rd(rd_wr),
        .split(cr_q[7]), .sel_code(cr_q[4:3]), .stream(cr_q[ST_W-1:0]),
        .kind(kind), .sel(sel), .maddr(maddr)
    );

    tsi_access_fsm #(.DW(DW), .MA_W(MA_W), .MEM_WAIT(MEM_WAIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .rd(rd_wr), .wdata(wdata),
        .kind(kind), .sel(sel), .maddr(maddr), .cr(cr_q),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .cr_we(cr_we),
        .ack_n(ack_n), .rdata(rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // control register, unimplemented bits kept at zero
    always_ff @(posedge clk) begin
        if (!rst_n)     cr_q <= '0;
        else if (cr_we) cr_q <= wdata & CR_KEEP;
    end

    assign proc_mode = cr_q[6];

    // R4: processor-mode flag only moves on a control write
    assert_pmode_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_we |=> $stable(proc_mode));

    // R6: split mode routes reads to data memory and writes to connection low
    assert_split_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && cr_q[7] |-> mem_sel == (mem_we ? 2'b10 : 2'b01));

    // R5: requested stream follows the control page
    assert_page_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[MA_W-1:CH_W] == cr_q[ST_W-1:0]);
endmodule

// File: tb/tsi_cpu_port_bench.sv
// Self-checking bench: directed corners then seeded random host traffic.
module tsi_cpu_port_bench;
    localparam int MEM_WAIT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ds = 1'b0, rd_wr = 1'b1, mem_gnt = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0, mem_rdata = '0;
    logic [7:0] rdata, mem_wdata;
    logic       ack_n, proc_mode, mem_req, mem_we;
    logic [1:0] mem_sel;
    logic [6:0] mem_addr;

    logic [7:0] dm [128];
    logic [7:0] cml[128];
    logic [7:0] cmh[128];
    logic [7:0] cr_model = 8'h00;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    tsi_cpu_port #(.MEM_WAIT(MEM_WAIT)) u_tsi_cpu_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack_n(ack_n),
        .proc_mode(proc_mode), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: acts on the grant edge, read byte valid next cycle
    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                case (mem_sel)
                    2'b10: cml[mem_addr] <= mem_wdata;
                    2'b11: cmh[mem_addr] <= mem_wdata;
                    default: dm[mem_addr] <= mem_wdata;
                endcase
            end else begin
                case (mem_sel)
                    2'b01: mem_rdata <= dm[mem_addr];
                    2'b10: mem_rdata <= cml[mem_addr];
                    default: mem_rdata <= cmh[mem_addr];
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [7:0] c, input bit rd);
        if (c[7]) return rd ? 2'b01 : 2'b10;
        return c[4:3];
    endfunction

    function automatic logic [7:0] exp_mem(input logic [1:0] s, input logic [6:0] i);
        case (s)
            2'b01:   return dm[i];
            2'b10:   return cml[i];
            default: return cmh[i] & 8'h05;
        endcase
    endfunction

    // one full host access with expectations from the bench model
    task automatic access(input bit rd, input logic [5:0] a, input logic [7:0] wd, input int gdelay);
        logic [1:0] s;
        logic [6:0] idx;
        logic [7:0] exp_rd;
        bit is_mem, seen, granted;
        int cyc, after, gd;
        string rt;
        s = exp_sel(cr_model, rd);
        idx = {cr_model[1:0], a[4:0]};
        is_mem = a[5] && s != 2'b00 && !(s == 2'b01 && !rd);
        rt = cr_model[7] ? "R6" : "R5";
        exp_rd = !a[5] ? cr_model : (is_mem ? exp_mem(s, idx) : 8'h00);
        seen = 0; granted = 0; cyc = 0; after = 0; gd = gdelay;
        @(negedge clk);
        rd_wr = rd; addr = a; wdata = wd; cs_n = 1'b0; ds = 1'b1;
        forever begin
            @(negedge clk);
            if (!ack_n) break;
            if (granted) after++;
            mem_gnt = 1'b0;
            if (mem_req && !granted) begin
                if (!seen) begin
                    seen = 1;
                    chk(mem_sel == s, rt, mem_sel, s);
                    chk(mem_addr == idx, "R5", mem_addr, idx);
                    chk(mem_we == !rd, rt, mem_we, !rd);
                    if (!rd) chk(mem_wdata == ((s == 2'b11) ? (wd & 8'h05) : wd), "R8",
                                 mem_wdata, (s == 2'b11) ? (wd & 8'h05) : wd);
                end else begin
                    chk(mem_sel == s && mem_addr == idx, "R9", mem_addr, idx);
                end
                if (gd == 0) begin mem_gnt = 1'b1; granted = 1; end
                else gd--;
            end
            cyc++;
            if (cyc > 100) begin chk(0, "R9", cyc, 0); break; end
        end
        chk(seen == is_mem, "R3", seen, is_mem);
        if (is_mem) chk(after == MEM_WAIT, "R9", after, MEM_WAIT);
        else        chk(cyc <= 4, "R3", cyc, 4);
        if (rd) chk(rdata == exp_rd, !a[5] ? "R2" : (is_mem ? (s == 2'b11 ? "R8" : "R11") : "R7"),
                    rdata, exp_rd);
        if (!a[5] && !rd) cr_model = wd & 8'hDB;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(!ack_n, "R10", ack_n, 0);
        end
        ds = 1'b0; cs_n = 1'b1;
        cyc = 0;
        while (!ack_n && cyc < 10) begin @(negedge clk); cyc++; end
        chk(ack_n && cyc <= 4, "R10", cyc, 4);
        chk(proc_mode == cr_model[6], "R4", proc_mode, cr_model[6]);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 128; i++) begin
            dm[i]  = 8'(i * 37 + 5);
            cml[i] = 8'(i) ^ 8'h5A;
            cmh[i] = 8'(i) ^ 8'hF3;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ack_n == 1'b1, "R1", ack_n, 1);
        chk(mem_req == 1'b0, "R1", mem_req, 0);
        chk(proc_mode == 1'b0, "R1", proc_mode, 0);
        rst_n = 1'b1;
        access(1, 6'h00, 8'h00, 0);                       // R1 readback 0x00
        // R2: low address bits ignored, unused bits dropped
        access(0, 6'h1F, 8'hFF, 0);
        access(1, 6'h05, 8'h00, 0);
        access(0, 6'h0A, 8'h52, 0);                       // normal, connection low, stream 2, pmode
        access(0, 6'h23, 8'hA7, 2);                       // R5 write connection low
        access(1, 6'h23, 8'h00, 1);                       // R11 read it back
        access(0, 6'h00, 8'h1B, 0);                       // connection high, stream 3
        access(0, 6'h3F, 8'hFF, 0);                       // R8 masked write
        access(1, 6'h3F, 8'h00, 3);                       // R8 masked read
        access(0, 6'h00, 8'h09, 0);                       // data memory, stream 1
        access(1, 6'h24, 8'h00, 0);                       // R11 data memory read
        access(0, 6'h24, 8'hEE, 0);                       // R7 write ignored
        access(1, 6'h24, 8'h00, 0);                       // R7 content unchanged
        access(0, 6'h00, 8'h42, 0);                       // reserved code 00
        access(1, 6'h30, 8'h00, 0);                       // R7 read returns 0
        access(0, 6'h30, 8'h77, 0);                       // R7 write ignored
        access(0, 6'h00, 8'h99, 0);                       // R6 split, code 11 ignored
        access(0, 6'h31, 8'h3C, 1);                       // R6 write to connection low
        access(1, 6'h31, 8'h00, 1);                       // R6 read from data memory
        for (int n = 0; n < 120; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2)       access(0, {1'b0, 5'($urandom)}, 8'($urandom), 0);
            else if (r == 2) access(1, {1'b0, 5'($urandom)}, 8'h00, 0);
            else             access(1'($urandom), {1'b1, 5'($urandom)}, 8'($urandom),
                                    $urandom_range(0, 4));
        end
        report();
    end
endmodule